// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Instruction Processor

This block is a small processor core that runs 16-bit instructions held in a 256-byte memory inside the block. Program and data share that memory. The core has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Each instruction takes three clock cycles: the high byte is fetched, then the low byte, and then the instruction executes.

A host fills memory through a byte-wide port while the core is stopped, then pulses `run`. The core starts at address 00 and runs until it meets a halt or an unimplemented opcode. The host then reads results back through the same port.

The top nibble of an instruction is the opcode. The other three nibbles name registers, a shift count or an 8-bit constant or address. Arithmetic sets no flags. The conditional jump compares the register it names with register 0.

Top module: `tiny_cpu_core`

## Requirements
- R1: After reset, `halted` is 1, `illegal` is 0 and all sixteen registers hold 00. Reset does not change memory contents.
- R2: While `halted` is 1, `host_we` writes `host_wdata` to memory at `host_addr`, and `host_rdata` shows the byte at `host_addr`. While the core runs, host writes are ignored and `host_rdata` is 00.
- R3: When `run` is seen high while halted, execution starts at PC 00. The byte at PC goes to the upper half of the instruction register and the byte at PC+1 to the lower half. PC then advances by 2, wrapping modulo 256. Every instruction takes exactly 3 cycles.
- R4: Opcode 1 (1RXY) loads register R from memory address XY. Opcode 2 (2RXY) loads register R with the constant XY. Opcode 3 (3RXY) writes register R to memory address XY.
- R5: Opcode 4 (40RS) copies register R (bits 7:4) into register S (bits 3:0).
- R6: Opcode 5 (5RST) writes (S + T) mod 256 into R. The carry is discarded.
- R7: Opcodes 7, 8 and 9 (RST) write the bitwise OR, AND and XOR of S and T into R, respectively.
- R8: Opcode A (AR0X) rotates register R right by X positions (X = bits 3:0). Bits leaving bit 0 re-enter at bit 7, so X and X mod 8 give the same result.
- R9: Opcode B (BRXY) loads PC with XY when register R equals register 0. Otherwise execution continues at the next instruction. With R = 0 the jump is always taken.
- R10: Opcode C stops the core with `illegal` at 0. Opcodes 0, 6, D, E and F stop the core with `illegal` at 1. `illegal` clears when the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Start request, sampled while halted |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 8 | Host memory address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Memory byte at host_addr while halted, else 00 |
| halted | output | 1 | Core is stopped |
| illegal | output | 1 | Last stop was caused by an unimplemented opcode |

## Verification
The assertions check, on every cycle, the rules that hold whatever program is running:
- the low-byte fetch always follows the high-byte fetch, and PC advances by exactly 2 across it;
- a start always begins at PC 00;
- a stopped core stays stopped without `run`;
- an untaken jump leaves PC alone;
- `illegal` never shows while running.

Data results can only be shown by the bench's programs. These cover sums with carry out, bitwise results on random operands, rotate counts of 0, 8 and 15, and the Fibonacci loop that exercises both taken and untaken branches. The same holds for PC wrap past FF, ignored host writes during a run, and cycle counts measured at the ports.

// File: rtl/tiny_cpu_pkg.sv
package tiny_cpu_pkg;

  typedef enum logic [3:0] {
    OP_LDM  = 4'h1,
    OP_LDI  = 4'h2,
    OP_STO  = 4'h3,
    OP_MOV  = 4'h4,
    OP_ADD  = 4'h5,
    OP_OR   = 4'h7,
    OP_AND  = 4'h8,
    OP_XOR  = 4'h9,
    OP_ROR  = 4'hA,
    OP_JEQ  = 4'hB,
    OP_STOP = 4'hC
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FHI   = 2'd1,
    ST_FLO   = 2'd2,
    ST_EXEC  = 2'd3
  } cpu_state_e;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
  import tiny_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]       sh;
  logic [2*DATA_W-1:0]   dbl;

  always_comb begin
    sh  = SH_W'(cnt % DATA_W);
    dbl = {a, a} >> sh;
    case (op)
      OP_ADD:  y = a + b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_ROR:  y = dbl[DATA_W-1:0];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W  = 8,
  parameter int REG_NUM = 16,
  localparam int IDX_W  = $clog2(REG_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_a,
  input  logic [IDX_W-1:0]  ra_b,
  input  logic [IDX_W-1:0]  ra_c,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_c,
  output logic [DATA_W-1:0] rd_zero
);
  logic [DATA_W-1:0] regs_q [REG_NUM];

  for (genvar i = 0; i < REG_NUM; i++) begin : g_reg
    logic en;
    assign en = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[i] <= '0;
      else if (en) regs_q[i] <= wdata;
    end
  end

  assign rd_a    = regs_q[ra_a];
  assign rd_b    = regs_q[ra_b];
  assign rd_c    = regs_q[ra_c];
  assign rd_zero = regs_q[0];
endmodule

// File: rtl/tiny_cpu_core.sv
module tiny_cpu_core
  import tiny_cpu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int REG_NUM = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              halted,
  output logic              illegal
);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int IR_W      = 2 * DATA_W;
  localparam int IDX_W     = $clog2(REG_NUM);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  cpu_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [IR_W-1:0]   ir_q, ir_d;
  logic              ill_q, ill_d;
  logic [DATA_W-1:0] mem [MEM_DEPTH];

  // instruction fields
  logic [3:0]        f_op, f_r, f_s, f_t;
  logic [ADDR_W-1:0] f_xy;
  assign f_op = ir_q[15:12];
  assign f_r  = ir_q[11:8];
  assign f_s  = ir_q[7:4];
  assign f_t  = ir_q[3:0];
  assign f_xy = ir_q[ADDR_W-1:0];

  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata, rd_a, rd_b, rd_c, rd_zero, alu_a, alu_y;
  logic [IDX_W-1:0]  ra_c;
  logic              exec, jump_hit;

  assign ra_c  = (f_op == OP_MOV) ? IDX_W'(f_s) : IDX_W'(f_r);
  assign alu_a = (f_op == OP_ROR) ? rd_c : rd_a;
  assign exec  = (st_q == ST_EXEC);
  assign jump_hit = (rd_c == rd_zero);

  cpu_regfile #(.DATA_W(DATA_W), .REG_NUM(REG_NUM)) u_rf (
    .clk(clk), .rst_n(rst_core_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(IDX_W'(f_s)), .ra_b(IDX_W'(f_t)), .ra_c(ra_c),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .rd_zero(rd_zero)
  );

  cpu_alu #(.DATA_W(DATA_W), .CNT_W(4)) u_alu (
    .op(f_op), .a(alu_a), .b(rd_b), .cnt(f_t), .y(alu_y)
  );

  // register-file write decode
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = IDX_W'(f_r);
    rf_wdata = alu_y;
    if (exec) begin
      case (f_op)
        OP_LDM: begin rf_we = 1'b1; rf_wdata = mem[f_xy]; end
        OP_LDI: begin rf_we = 1'b1; rf_wdata = DATA_W'(f_xy); end
        OP_MOV: begin rf_we = 1'b1; rf_waddr = IDX_W'(f_t); rf_wdata = rd_c; end
        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
        default: ;
      endcase
    end
  end

  // sequencer next state
  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    ir_d  = ir_q;
    ill_d = ill_q;
    case (st_q)
      ST_IDLE: if (run) begin
        st_d  = ST_FHI;
        pc_d  = '0;
        ill_d = 1'b0;
      end
      ST_FHI: begin
        ir_d[IR_W-1:DATA_W] = mem[pc_q];
        st_d = ST_FLO;
      end
      ST_FLO: begin
        ir_d[DATA_W-1:0] = mem[ADDR_W'(pc_q + 1'b1)];
        pc_d = ADDR_W'(pc_q + 2'd2);
        st_d = ST_EXEC;
      end
      ST_EXEC: begin
        st_d = ST_FHI;
        case (f_op)
          OP_LDM, OP_LDI, OP_STO, OP_MOV, OP_ADD,
          OP_OR, OP_AND, OP_XOR, OP_ROR: ;
          OP_JEQ:  if (jump_hit) pc_d = f_xy;
          OP_STOP: st_d = ST_IDLE;
          default: begin st_d = ST_IDLE; ill_d = 1'b1; end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      ir_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      ill_q <= ill_d;
    end
  end

  // unified memory: core store has priority, host only while stopped
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [DATA_W-1:0] mem_wd;
  always_comb begin
    mem_we = 1'b0;
    mem_wa = host_addr;
    mem_wd = host_wdata;
    if (exec && f_op == OP_STO) begin
      mem_we = 1'b1; mem_wa = f_xy; mem_wd = rd_c;
    end else if (st_q == ST_IDLE && host_we) begin
      mem_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  assign halted     = (st_q == ST_IDLE);
  assign illegal    = ill_q;
  assign host_rdata = halted ? mem[host_addr] : '0;

  // ---- assertions ----
  assert_fetch_order_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    st_q == ST_FHI |=> st_q == ST_FLO);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    st_q == ST_FLO |=> pc_q == ADDR_W'($past(pc_q) + 2'd2));

  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (halted && run) |=> (pc_q == '0 && st_q == ST_FHI && !illegal));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (halted && !run) |=> (halted && $stable(illegal)));

  assert_illegal_only_stopped_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    illegal |-> halted);

  assert_jump_miss_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec && f_op == OP_JEQ && rd_c != rd_zero) |=> pc_q == $past(pc_q));
endmodule

// File: tb/tiny_cpu_core_test.sv
`timescale 1ns/1ps
module tiny_cpu_core_test;
  logic       clk = 1'b0;
  logic       rst_n, run, host_we;
  logic [7:0] host_addr, host_wdata, host_rdata;
  logic       halted, illegal;
  int         checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  tiny_cpu_core uut (
    .clk(clk), .rst_n(rst_n), .run(run), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .halted(halted), .illegal(illegal)
  );

  function automatic logic [7:0] rotr(input logic [7:0] v, input int k);
    logic [7:0] r = v;
    for (int i = 0; i < k; i++) r = {r[0], r[7:1]};
    return r;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    wr(a, w[15:8]); wr(8'(a + 1), w[7:0]);
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); host_addr = a; #1;
    chk(host_rdata, exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // returns the number of clock cycles spent running
  task automatic go(output int cyc);
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
    cyc = 0;
    while (!halted && cyc < 5000) begin cyc++; @(negedge clk); end
    if (cyc >= 5000) chk(0, 1, "R10 run never stopped");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [7:0] a, b, c;
    int k;
    rst_n = 1'b1; run = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    void'($urandom(32'd2024));
    do_reset();
    chk(halted, 1, "R1 halted after reset");
    chk(illegal, 0, "R1 illegal after reset");

    // register reset value seen through stores; C000 timing
    put(8'h00, 16'h3A50); put(8'h02, 16'h3F51); put(8'h04, 16'hC000);
    wr(8'h50, 8'hEE); wr(8'h51, 8'hEE);
    go(cyc);
    chk(cyc, 9, "R3 three cycles per instruction");
    rd(8'h50, 8'h00, "R1 register A cleared");
    rd(8'h51, 8'h00, "R1 register F cleared");
    chk(illegal, 0, "R10 normal stop");

    // mixed random / directed data path programs
    for (int it = 0; it < 23; it++) begin
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
      k = (it == 0) ? 0 : (it == 1) ? 8 : (it == 2) ? 15 : int'($urandom % 16);
      if (it == 3) begin a = 8'hFF; b = 8'h9D; k = 1; end
      put(8'h00, {8'h21, a}); put(8'h02, {8'h22, b});
      put(8'h04, 16'h5312);   put(8'h06, 16'h3350);
      put(8'h08, 16'h7412);   put(8'h0A, 16'h3451);
      put(8'h0C, 16'h8512);   put(8'h0E, 16'h3552);
      put(8'h10, 16'h9612);   put(8'h12, 16'h3653);
      put(8'h14, 16'h4017);   put(8'h16, 16'h3754);
      put(8'h18, {12'hA20, 4'(k)}); put(8'h1A, 16'h3255);
      put(8'h1C, 16'h1860);   put(8'h1E, 16'h3856);
      put(8'h20, 16'hC000);   wr(8'h60, c);
      go(cyc);
      if (it == 0) chk(cyc, 51, "R3 17 instruction program cycles");
      rd(8'h50, 8'(a + b), "R6 add");
      rd(8'h51, a | b, "R7 or");
      rd(8'h52, a & b, "R7 and");
      rd(8'h53, a ^ b, "R7 xor");
      rd(8'h54, a, "R5 move");
      rd(8'h55, rotr(b, k), "R8 rotate");
      rd(8'h56, c, "R4 load direct");
    end

    // branch not taken, then taken
    put(8'h00, 16'h2105); put(8'h02, 16'h2006); put(8'h04, 16'hB10A);
    put(8'h06, 16'h3150); put(8'h08, 16'hC000);
    put(8'h0A, 16'h3051); put(8'h0C, 16'hC000);
    wr(8'h50, 8'h00); wr(8'h51, 8'h00);
    go(cyc);
    rd(8'h50, 8'h05, "R9 not taken stores");
    rd(8'h51, 8'h00, "R9 not taken skips");
    put(8'h02, 16'h2005); wr(8'h50, 8'h00);
    go(cyc);
    rd(8'h51, 8'h05, "R9 taken stores");
    rd(8'h50, 8'h00, "R9 taken skips");

    // loop with branches: tenth Fibonacci number
    put(8'h00, 16'hB020);
    put(8'h20, 16'h2000); put(8'h22, 16'h2100); put(8'h24, 16'h2201);
    put(8'h26, 16'h2408); put(8'h28, 16'h25FF); put(8'h2A, 16'h5312);
    put(8'h2C, 16'h4021); put(8'h2E, 16'h4032); put(8'h30, 16'h5445);
    put(8'h32, 16'hB436); put(8'h34, 16'hB02A); put(8'h36, 16'h3240);
    put(8'h38, 16'hC000);
    go(cyc);
    rd(8'h40, 8'h22, "R9 loop result");

    // PC wrap from FE to 00 (registers cleared by reset first)
    do_reset();
    put(8'h00, 16'h2000); put(8'h02, 16'hB40A); put(8'h04, 16'h3450);
    put(8'h06, 16'hC000); put(8'h0A, 16'hB0FE); put(8'hFE, 16'h2455);
    go(cyc);
    rd(8'h50, 8'h55, "R3 pc wraps");

    // illegal opcodes, then clearing
    foreach (k_ill[i]) ;
    for (int i = 0; i < 5; i++) begin
      logic [3:0] opc;
      opc = (i == 0) ? 4'h0 : (i == 1) ? 4'h6 : (i == 2) ? 4'hD : (i == 3) ? 4'hE : 4'hF;
      put(8'h00, {opc, 12'h000});
      go(cyc);
      chk(cyc, 3, "R10 illegal stops at once");
      chk(illegal, 1, "R10 illegal flag");
    end
    put(8'h00, 16'hC000);
    go(cyc);
    chk(illegal, 0, "R10 flag clears on run");

    // host port during a run, then reset keeps memory
    wr(8'h70, 8'h11);
    put(8'h00, 16'hB000);
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
    repeat (4) @(negedge clk);
    chk(halted, 0, "R2 core running");
    host_addr = 8'h70; #1;
    chk(host_rdata, 0, "R2 read blank while running");
    wr(8'h70, 8'hAA);
    do_reset();
    chk(halted, 1, "R1 halted after reset");
    rd(8'h70, 8'h11, "R2 write ignored while running");
    rd(8'h00, 8'hB0, "R1 memory kept over reset");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int k_ill [0:0];
endmodule